// File: doc/BRIEF.md
# Priority-Aging Preemptive Slot Scheduler

This block makes the per-slot placement decisions for a slotted packet switch. The switch buffers packets in fixed-length delay stages. Each destination output owns a short queue of delay positions, and a small set of unit-length recirculation loops is shared by all outputs. In every slot the block sees up to `M_FB` packets coming back from the loops and `N_EXT` packets arriving from outside. Each packet carries a destination and a 3-bit priority tag. The block decides for every packet whether it takes a delay position of its destination, goes into a recirculation loop, or is dropped.

All inputs are handled in one pass, in order of priority. When priorities are equal, the lower input index goes first. Loop returns sit at indices 0 to `M_FB-1` and external inputs follow them, so a loop return wins a tie against an external packet. A packet that cannot get a delay position falls back to the lowest free loop, and its tag is raised by one, saturating at 5. Each time it recirculates it therefore gains rank, so it cannot circulate for ever. Decisions are registered and appear one clock after the slot's inputs. One clock is one slot.

Top module: `prio_slot_sched`

## Requirements
- R1: While `rst_ni` is low, and after it rises, every decision output is 0 and all delay positions are free.
- R2: An input whose valid bit is low gets kind 0 (idle), index 0 and zero tags, whatever its tag and destination are. It claims no position and no loop, so a valid packet in the same slot behaves as if the idle input were absent.
- R3: A valid packet takes the lowest-numbered free delay position of its destination and reports kind 1 with that position in `place_idx_o`. Position k means the packet leaves k slots later.
- R4: Between slots, each occupied delay position moves down by one. Position 0 empties, and a packet held at position k is at k-1 in the next slot.
- R5: Packets are served in descending order of their tag, with loop returns and external packets ranked together in one pass. A higher tag therefore never loses a position or loop to a lower one.
- R6: Among equal tags, the lower input index is served first. Inputs 0 to `M_FB-1` are loop returns and rank ahead of the external inputs.
- R7: A packet that finds no free delay position takes the lowest-indexed loop that is still free in this slot and reports kind 2 with the loop number in `place_idx_o`. Each loop holds at most one packet per slot.
- R8: A packet that finds neither a delay position nor a loop reports kind 3 and sets its `drop_o` bit, with its tag on `drop_prio_o`. A drop happens only when every loop is taken, and every loop-bound packet in the slot has a tag at least as high as any dropped one.
- R9: For a loop-bound packet, `loop_prio_o` is its tag plus one, held at 5 when the tag is already 5 or more. For any other packet it is 0.
- R10: No delay position is assigned twice. A packet is placed only on a position that is free after the shift and after earlier placements in the same slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | NI | Packet present per input (loop returns first) |
| in_dest_i | input | NI*DW | Destination output per input |
| in_prio_i | input | NI*3 | Priority tag per input |
| place_kind_o | output | NI*2 | 0 idle, 1 delay position, 2 loop, 3 drop |
| place_idx_o | output | NI*IW | Delay position or loop number |
| loop_prio_o | output | NI*3 | Aged tag for loop-bound packets, else 0 |
| drop_o | output | NI | Packet dropped this slot |
| drop_prio_o | output | NI*3 | Tag of a dropped packet, else 0 |

## Verification
The assertions assume that every valid tag lies between 1 and 5 and that every destination is below `N_OUT`. Under that assumption, the aging and loop-versus-drop properties relate only values that the scheduler can legally see. The stimulus draws tags from 1 to 5 and destinations from the full output range. It varies the load between light and saturating, so queues fill, loops run out and drops occur. Directed slots cover the tie order, the saturation of aging and the invalid-input case.

// File: rtl/psched_pkg.sv
package psched_pkg;
  localparam int PW = 3;
  localparam logic [PW-1:0] PRIO_TOP = 3'd5;

  typedef enum logic [1:0] {
    KIND_IDLE = 2'd0,
    KIND_FF   = 2'd1,
    KIND_LOOP = 2'd2,
    KIND_DROP = 2'd3
  } kind_e;
endpackage

// File: rtl/psched_age.sv
module psched_age
  import psched_pkg::*;
(
  input  logic [PW-1:0] prio_i,
  output logic [PW-1:0] aged_o
);
  always_comb begin
    if (prio_i >= PRIO_TOP) aged_o = PRIO_TOP;
    else                    aged_o = prio_i + PW'(1);
  end
endmodule

// File: rtl/psched_occ.sv
module psched_occ #(
  parameter int DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] place_i,
  output logic [DEPTH-1:0] occ_o
);
  logic [DEPTH-1:0] occ_q;

  // occupancy as seen at the start of the next slot
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else         occ_q <= (occ_q | place_i) >> 1;
  end

  assign occ_o = occ_q;

  assert_no_double_book_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (place_i & occ_q) == '0);

  assert_shift_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(place_i[DEPTH-1]) |-> occ_q[DEPTH-2]);
endmodule

// File: rtl/psched_alloc.sv
module psched_alloc
  import psched_pkg::*;
#(
  parameter int NI    = 6,
  parameter int M_FB  = 2,
  parameter int N_OUT = 4,
  parameter int DEPTH = 4,
  parameter int DW    = 2,
  parameter int IW    = 2
) (
  input  logic [NI-1:0]          valid_i,
  input  logic [NI*DW-1:0]       dest_i,
  input  logic [NI*PW-1:0]       prio_i,
  input  logic [N_OUT*DEPTH-1:0] occ_i,
  output logic [NI*2-1:0]        kind_o,
  output logic [NI*IW-1:0]       idx_o,
  output logic [N_OUT*DEPTH-1:0] place_o,
  output logic [M_FB-1:0]        loop_take_o
);
  localparam int NLV = 1 << PW;

  logic [N_OUT*DEPTH-1:0] occ_w;
  logic [M_FB-1:0]        loop_w;
  logic [DW-1:0]          dst;
  logic                   hit;

  // level scan: highest tag first, index order inside a level
  always_comb begin
    occ_w   = occ_i;
    loop_w  = '0;
    place_o = '0;
    kind_o  = '0;
    idx_o   = '0;
    dst     = '0;
    hit     = 1'b0;
    for (int lv = NLV - 1; lv >= 0; lv--) begin
      for (int i = 0; i < NI; i++) begin
        if (valid_i[i] && prio_i[i*PW +: PW] == PW'(lv)) begin
          dst = dest_i[i*DW +: DW];
          hit = 1'b0;
          if (int'(dst) < N_OUT) begin
            for (int k = 0; k < DEPTH; k++) begin
              if (!hit && !occ_w[int'(dst)*DEPTH + k]) begin
                hit = 1'b1;
                occ_w[int'(dst)*DEPTH + k]   = 1'b1;
                place_o[int'(dst)*DEPTH + k] = 1'b1;
                kind_o[i*2 +: 2]   = KIND_FF;
                idx_o[i*IW +: IW]  = IW'(k);
              end
            end
          end
          for (int j = 0; j < M_FB; j++) begin
            if (!hit && !loop_w[j]) begin
              hit = 1'b1;
              loop_w[j]         = 1'b1;
              kind_o[i*2 +: 2]  = KIND_LOOP;
              idx_o[i*IW +: IW] = IW'(j);
            end
          end
          if (!hit) kind_o[i*2 +: 2] = KIND_DROP;
        end
      end
    end
    loop_take_o = loop_w;
  end
endmodule

// File: rtl/prio_slot_sched.sv
module prio_slot_sched
  import psched_pkg::*;
#(
  parameter int N_EXT = 4,
  parameter int M_FB  = 2,
  parameter int N_OUT = 4,
  parameter int DEPTH = 4,
  localparam int NI   = N_EXT + M_FB,
  localparam int DW   = (N_OUT > 1) ? $clog2(N_OUT) : 1,
  localparam int IWD  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int IWL  = (M_FB > 1) ? $clog2(M_FB) : 1,
  localparam int IW   = (IWD > IWL) ? IWD : IWL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NI-1:0]    in_valid_i,
  input  logic [NI*DW-1:0] in_dest_i,
  input  logic [NI*3-1:0]  in_prio_i,
  output logic [NI*2-1:0]  place_kind_o,
  output logic [NI*IW-1:0] place_idx_o,
  output logic [NI*3-1:0]  loop_prio_o,
  output logic [NI-1:0]    drop_o,
  output logic [NI*3-1:0]  drop_prio_o
);
  logic [N_OUT*DEPTH-1:0] occ;
  logic [N_OUT*DEPTH-1:0] place;
  logic [M_FB-1:0]        loop_take;
  logic [NI*2-1:0]        kind_d;
  logic [NI*IW-1:0]       idx_d;
  logic [NI*PW-1:0]       aged;
  logic [NI*PW-1:0]       loop_prio_d;
  logic [NI*PW-1:0]       drop_prio_d;
  logic [NI-1:0]          drop_d;

  psched_alloc #(
    .NI(NI), .M_FB(M_FB), .N_OUT(N_OUT), .DEPTH(DEPTH), .DW(DW), .IW(IW)
  ) i_alloc (
    .valid_i     (in_valid_i),
    .dest_i      (in_dest_i),
    .prio_i      (in_prio_i),
    .occ_i       (occ),
    .kind_o      (kind_d),
    .idx_o       (idx_d),
    .place_o     (place),
    .loop_take_o (loop_take)
  );

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    psched_occ #(.DEPTH(DEPTH)) i_occ (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .place_i (place[o*DEPTH +: DEPTH]),
      .occ_o   (occ[o*DEPTH +: DEPTH])
    );
  end

  for (genvar i = 0; i < NI; i++) begin : g_in
    psched_age i_age (
      .prio_i (in_prio_i[i*PW +: PW]),
      .aged_o (aged[i*PW +: PW])
    );
    assign drop_d[i] = kind_d[i*2 +: 2] == KIND_DROP;
    assign loop_prio_d[i*PW +: PW] = (kind_d[i*2 +: 2] == KIND_LOOP) ? aged[i*PW +: PW] : '0;
    assign drop_prio_d[i*PW +: PW] = drop_d[i] ? in_prio_i[i*PW +: PW] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      place_kind_o <= '0;
      place_idx_o  <= '0;
      loop_prio_o  <= '0;
      drop_o       <= '0;
      drop_prio_o  <= '0;
    end else begin
      place_kind_o <= kind_d;
      place_idx_o  <= idx_d;
      loop_prio_o  <= loop_prio_d;
      drop_o       <= drop_d;
      drop_prio_o  <= drop_prio_d;
    end
  end

  // ---- checks on the registered decisions ----
  logic [M_FB-1:0][NI-1:0] loop_hits;
  logic [NI-1:0]           loop_any;
  logic [PW-1:0]           drop_max;
  logic [PW-1:0]           loop_min;

  always_comb begin
    loop_hits = '0;
    loop_any  = '0;
    drop_max  = '0;
    loop_min  = '1;
    for (int i = 0; i < NI; i++) begin
      if (place_kind_o[i*2 +: 2] == KIND_LOOP) begin
        loop_any[i] = 1'b1;
        for (int j = 0; j < M_FB; j++)
          if (int'(place_idx_o[i*IW +: IW]) == j) loop_hits[j][i] = 1'b1;
        if (loop_prio_o[i*PW +: PW] < loop_min) loop_min = loop_prio_o[i*PW +: PW];
      end
      if (drop_o[i] && drop_prio_o[i*PW +: PW] > drop_max) drop_max = drop_prio_o[i*PW +: PW];
    end
  end

  for (genvar j = 0; j < M_FB; j++) begin : g_loop_chk
    assert_loop_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $countones(loop_hits[j]) <= 1);
  end

  assert_drop_needs_full_loops_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|drop_o) |-> ($countones(loop_any) == M_FB));

  assert_drop_below_loop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|drop_o) && (|loop_any)) |-> (drop_max <= loop_min));

  for (genvar i = 0; i < NI; i++) begin : g_in_chk
    assert_idle_when_invalid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !in_valid_i[i] |=> (place_kind_o[i*2 +: 2] == KIND_IDLE));

    assert_aged_tag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (place_kind_o[i*2 +: 2] == KIND_LOOP) |->
        (loop_prio_o[i*PW +: PW] == (($past(in_prio_i[i*PW +: PW]) > 3'd4) ? 3'd5
                                     : $past(in_prio_i[i*PW +: PW]) + 3'd1)));

    assert_drop_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      drop_o[i] == (place_kind_o[i*2 +: 2] == KIND_DROP));
  end
endmodule

// File: tb/test_prio_slot_sched.sv
`timescale 1ns/1ps
module test_prio_slot_sched;
  localparam int N_EXT = 4;
  localparam int M_FB  = 2;
  localparam int N_OUT = 4;
  localparam int DEPTH = 4;
  localparam int NI    = N_EXT + M_FB;
  localparam int DW    = 2;
  localparam int IW    = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [NI-1:0]    in_valid = '0;
  logic [NI*DW-1:0] in_dest = '0;
  logic [NI*3-1:0]  in_prio = '0;
  logic [NI*2-1:0]  place_kind;
  logic [NI*IW-1:0] place_idx;
  logic [NI*3-1:0]  loop_prio;
  logic [NI-1:0]    drop;
  logic [NI*3-1:0]  drop_prio;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int m_occ [N_OUT][DEPTH];
  int e_kind[NI];
  int e_idx [NI];
  int e_lp  [NI];
  int e_dp  [NI];

  always #2.5 clk = ~clk;

  prio_slot_sched #(.N_EXT(N_EXT), .M_FB(M_FB), .N_OUT(N_OUT), .DEPTH(DEPTH)) i_prio_slot_sched (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .in_valid_i   (in_valid),
    .in_dest_i    (in_dest),
    .in_prio_i    (in_prio),
    .place_kind_o (place_kind),
    .place_idx_o  (place_idx),
    .loop_prio_o  (loop_prio),
    .drop_o       (drop),
    .drop_prio_o  (drop_prio)
  );

  task automatic chk(string tag, string what, int i, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s in%0d actual=%0d expected=%0d", tag, what, i, act, exp);
    end
  endtask

  // reference: pick best remaining input by selection, then place
  task automatic model_slot();
    bit used[NI];
    bit loop_busy[M_FB];
    for (int i = 0; i < NI; i++) begin
      used[i] = 0; e_kind[i] = 0; e_idx[i] = 0; e_lp[i] = 0; e_dp[i] = 0;
    end
    for (int j = 0; j < M_FB; j++) loop_busy[j] = 0;
    for (int s = 0; s < NI; s++) begin
      int best = -1;
      for (int i = 0; i < NI; i++)
        if (in_valid[i] && !used[i])
          if (best < 0 || int'(in_prio[i*3 +: 3]) > int'(in_prio[best*3 +: 3])) best = i;
      if (best >= 0) begin
        int d = int'(in_dest[best*DW +: DW]);
        int p = int'(in_prio[best*3 +: 3]);
        bit ok = 0;
        used[best] = 1;
        for (int k = 0; k < DEPTH; k++)
          if (!ok && m_occ[d][k] == 0) begin
            ok = 1; m_occ[d][k] = 1; e_kind[best] = 1; e_idx[best] = k;
          end
        for (int j = 0; j < M_FB; j++)
          if (!ok && !loop_busy[j]) begin
            ok = 1; loop_busy[j] = 1; e_kind[best] = 2; e_idx[best] = j;
            e_lp[best] = (p >= 5) ? 5 : p + 1;
          end
        if (!ok) begin
          e_kind[best] = 3; e_dp[best] = p;
        end
      end
    end
    for (int o = 0; o < N_OUT; o++) begin
      for (int k = 0; k < DEPTH - 1; k++) m_occ[o][k] = m_occ[o][k+1];
      m_occ[o][DEPTH-1] = 0;
    end
  endtask

  task automatic run_slot(string tag);
    model_slot();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < NI; i++) begin
      chk(tag, "kind",      i, int'(place_kind[i*2 +: 2]), e_kind[i]);
      chk(tag, "idx",       i, int'(place_idx[i*IW +: IW]), e_idx[i]);
      chk(tag, "loop_prio", i, int'(loop_prio[i*3 +: 3]), e_lp[i]);
      chk(tag, "drop",      i, int'(drop[i]), (e_kind[i] == 3) ? 1 : 0);
      chk(tag, "drop_prio", i, int'(drop_prio[i*3 +: 3]), e_dp[i]);
    end
  endtask

  task automatic set_in(int i, bit v, int d, int p);
    in_valid[i] = v;
    in_dest[i*DW +: DW] = DW'(d);
    in_prio[i*3 +: 3]   = 3'(p);
  endtask

  task automatic clear_in();
    in_valid = '0; in_dest = '0; in_prio = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5.0);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int o = 0; o < N_OUT; o++)
      for (int k = 0; k < DEPTH; k++) m_occ[o][k] = 0;

    // R1: outputs quiet during and after reset
    repeat (3) @(negedge clk);
    chk("R1", "kind_rst", 0, int'(place_kind), 0);
    chk("R1", "drop_rst", 0, int'(drop), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1", "kind_post", 0, int'(place_kind), 0);
    chk("R1", "idx_post", 0, int'(place_idx), 0);

    // R2/R3: invalid high-tag input claims nothing
    clear_in();
    set_in(0, 0, 1, 5);
    set_in(4, 1, 1, 3);
    run_slot("R2_R3");

    // R6: equal tags, index order fills positions 0..3
    clear_in();
    for (int i = 0; i < 4; i++) set_in(i, 1, 0, 2);
    run_slot("R6_R3");

    // R4: after shift only position 3 is free
    clear_in();
    set_in(5, 1, 0, 1);
    run_slot("R4");

    // R5/R7/R8: queue has one slot; tags decide FF, loops, drop
    clear_in();
    set_in(5, 1, 0, 2);
    set_in(3, 1, 0, 4);
    set_in(1, 1, 0, 5);
    set_in(2, 1, 0, 1);
    run_slot("R5_R7_R8");

    // R9/R6: three top tags, loop return wins the tie, aging saturates
    clear_in();
    set_in(4, 1, 0, 5);
    set_in(0, 1, 0, 5);
    set_in(2, 1, 0, 5);
    run_slot("R9_R6");

    // R10: drain, then random traffic
    clear_in();
    repeat (4) run_slot("R10_idle");
    for (int t = 0; t < 600; t++) begin
      int load = (t < 200) ? 30 : ((t < 400) ? 70 : 100);
      clear_in();
      for (int i = 0; i < NI; i++)
        set_in(i, ($urandom % 100) < load, $urandom % N_OUT, 1 + ($urandom % 5));
      run_slot("R3_R5_R7_R8_R10");
    end
    clear_in();
    finish_run();
  end
endmodule